// File: doc/BRIEF.md
# Flow-Control Lane Training Generator

This block sits in front of the flow-control output pins of a link interface. These pins are a start-of-frame pin, a 4-bit data bus, a parity pin and a ready/backpressure pin, which together make a 7-bit word. Most of the time the block passes the normal flow-control word from the framing logic straight to the pins. When asked, it replaces that word with a deskew training sequence so that the far end can align its sampling of the seven pins.

Each training period is 20 phases long. In the first ten phases the pins carry one fixed word. In the last ten phases they carry the bitwise complement of that word. The period is repeated a programmable number of times, called the repeat count. The repeat count is captured when training starts, so later changes on its input do not affect a sequence already under way. A count of zero means no training. There is no leading idle word: the first training phase already carries the pattern.

The block advances one phase per cycle of its phase clock. If the pins run at double data rate, a serializer further down the path maps each phase to one edge. A one-cycle done pulse marks the final phase, and in the next cycle the block is back in passthrough.

Top module: `fc_train_gen`

## Requirements
- R1: While reset is asserted, busy_o and done_o are 0 and the pin word equals the normal input word.
- R2: While not training, out_sof_o, out_dat_o, out_par_o and out_srb_o equal norm_sof_i, norm_dat_i, norm_par_i and norm_srb_i in the same cycle.
- R3: A start_i sampled high while idle, with a nonzero repeat count A, makes busy_o high from the next cycle for exactly 20·A consecutive cycles.
- R4: In training phases 1 to 10 of every period, the pins carry sof=1, dat=4'hC, par=0, srb=0.
- R5: In training phases 11 to 20 of every period, the pins carry sof=0, dat=4'h3, par=1, srb=1.
- R6: A start_i sampled with a repeat count of 0 starts no training: busy_o stays 0 and passthrough continues.
- R7: The repeat count is captured at start. Changes on alpha_i during training do not change the length or the pattern.
- R8: done_o is high for exactly one cycle, the final phase 20·A. In the following cycle busy_o is 0 and passthrough resumes.
- R9: start_i while training is ignored. It neither restarts nor extends the sequence.
- R10: During training the normal input word has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one phase per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a training sequence |
| alpha_i | input | ALPHA_W | Repeat count, captured at start |
| norm_sof_i | input | 1 | Normal start-of-frame value |
| norm_dat_i | input | 4 | Normal data value |
| norm_par_i | input | 1 | Normal parity value |
| norm_srb_i | input | 1 | Normal ready/backpressure value |
| out_sof_o | output | 1 | Start-of-frame pin |
| out_dat_o | output | 4 | Data pins |
| out_par_o | output | 1 | Parity pin |
| out_srb_o | output | 1 | Ready/backpressure pin |
| busy_o | output | 1 | Training in progress |
| done_o | output | 1 | Final training phase |

## Verification
The bench sweeps the repeat count from 0 to 6, plus 255, and checks every phase against an expected word worked out from the phase index.

- **Half boundary:** a counter that is off by one at the boundary between halves would show the complement word one phase early or late, and that phase would miscompare.
- **Period wrap:** a design that failed to wrap the phase counter, or that mis-decremented the count, would give a busy window of the wrong length.
- **Done timing:** a done pulse that fired on the wrong period would light outside phase 20·A.
- **Captured count:** one run scrambles alpha_i every cycle during training. A design that reads the count live would end early or late.
- **Start while busy:** one run holds start_i high throughout training. A design that re-arms would extend the sequence.
- **Zero count:** a design that treated zero as a large count would begin training when none was asked for.

// File: rtl/fc_train_pkg.sv
package fc_train_pkg;

    localparam int DAT_W = 4;

    typedef struct packed {
        logic             sof;
        logic [DAT_W-1:0] dat;
        logic             par;
        logic             srb;
    } fc_word_t;

    localparam int WORD_W = $bits(fc_word_t);

    // Word for the first half of a training period; the second half is its complement
    localparam fc_word_t TRAIN_LO_HALF = '{sof: 1'b1, dat: 4'hC, par: 1'b0, srb: 1'b0};

endpackage

// File: rtl/fc_train_ctrl.sv
module fc_train_ctrl #(
    parameter int ALPHA_W  = 8,
    parameter int HALF_LEN = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ALPHA_W-1:0] alpha_i,
    output logic               busy_o,
    output logic               second_half_o,
    output logic               done_o
);
    localparam int PERIOD = 2 * HALF_LEN;
    localparam int PH_W   = $clog2(PERIOD);
    localparam logic [PH_W-1:0]    LAST_PH = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0]    HALF_PH = PH_W'(HALF_LEN);
    localparam logic [ALPHA_W-1:0] ONE_REP = ALPHA_W'(1);

    typedef struct packed {
        logic               busy;
        logic [PH_W-1:0]    phase;
        logic [ALPHA_W-1:0] left;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  last_phase;

    always_comb begin
        st_d       = st_q;
        last_phase = st_q.busy && (st_q.phase == LAST_PH) && (st_q.left == ONE_REP);
        if (!st_q.busy) begin
            if (start_i && (alpha_i != '0)) begin
                st_d.busy  = 1'b1;
                st_d.phase = '0;
                st_d.left  = alpha_i;
            end
        end else if (st_q.phase == LAST_PH) begin
            st_d.phase = '0;
            st_d.left  = st_q.left - ONE_REP;
            if (st_q.left == ONE_REP) begin
                st_d.busy = 1'b0;
            end
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o        = st_q.busy;
    assign second_half_o = (st_q.phase >= HALF_PH);
    assign done_o        = last_phase;

endmodule

// File: rtl/fc_train_pattern.sv
module fc_train_pattern
    import fc_train_pkg::*;
(
    input  logic     second_half_i,
    output fc_word_t word_o
);
    always_comb begin
        if (second_half_i) begin
            word_o = ~TRAIN_LO_HALF;
        end else begin
            word_o = TRAIN_LO_HALF;
        end
    end
endmodule

// File: rtl/fc_word_mux.sv
module fc_word_mux #(
    parameter int W = 7
) (
    input  logic         sel_train_i,
    input  logic [W-1:0] train_i,
    input  logic [W-1:0] norm_i,
    output logic [W-1:0] pin_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pin_o[b] = sel_train_i ? train_i[b] : norm_i[b];
    end
endmodule

// File: rtl/fc_train_gen.sv
module fc_train_gen
    import fc_train_pkg::*;
#(
    parameter int ALPHA_W  = 8,
    parameter int HALF_LEN = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ALPHA_W-1:0] alpha_i,
    input  logic               norm_sof_i,
    input  logic [3:0]         norm_dat_i,
    input  logic               norm_par_i,
    input  logic               norm_srb_i,
    output logic               out_sof_o,
    output logic [3:0]         out_dat_o,
    output logic               out_par_o,
    output logic               out_srb_o,
    output logic               busy_o,
    output logic               done_o
);
    logic     busy_w, second_half_w, done_w;
    fc_word_t norm_w, train_w, pin_w;

    assign norm_w = '{sof: norm_sof_i, dat: norm_dat_i, par: norm_par_i, srb: norm_srb_i};

    fc_train_ctrl #(
        .ALPHA_W (ALPHA_W),
        .HALF_LEN(HALF_LEN)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .alpha_i      (alpha_i),
        .busy_o       (busy_w),
        .second_half_o(second_half_w),
        .done_o       (done_w)
    );

    fc_train_pattern u_pat (
        .second_half_i(second_half_w),
        .word_o       (train_w)
    );

    fc_word_mux #(
        .W(WORD_W)
    ) u_mux (
        .sel_train_i(busy_w),
        .train_i    (train_w),
        .norm_i     (norm_w),
        .pin_o      (pin_w)
    );

    assign out_sof_o = pin_w.sof;
    assign out_dat_o = pin_w.dat;
    assign out_par_o = pin_w.par;
    assign out_srb_o = pin_w.srb;
    assign busy_o    = busy_w;
    assign done_o    = done_w;

endmodule

// File: rtl/fc_train_chk.sv
module fc_train_chk #(
    parameter int ALPHA_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [ALPHA_W-1:0] alpha_i,
    input logic               norm_sof_i,
    input logic [3:0]         norm_dat_i,
    input logic               norm_par_i,
    input logic               norm_srb_i,
    input logic               out_sof_o,
    input logic [3:0]         out_dat_o,
    input logic               out_par_o,
    input logic               out_srb_o,
    input logic               busy_o,
    input logic               done_o
);
    logic [6:0] pin_w, norm_w;
    assign pin_w  = {out_sof_o, out_dat_o, out_par_o, out_srb_o};
    assign norm_w = {norm_sof_i, norm_dat_i, norm_par_i, norm_srb_i};

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (pin_w == norm_w));

    // R3
    start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (alpha_i != '0)) |=> busy_o);

    // R4
    first_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (pin_w == 7'b1110000));

    // R5
    train_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((pin_w == 7'b1110000) || (pin_w == 7'b0001111)));

    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (alpha_i == '0)) |=> !busy_o);

    // R8
    done_in_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R8
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o));

    // R8
    end_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_state_chk: assert (!busy_o && !done_o);
        end
    end
endmodule

bind fc_train_gen fc_train_chk #(.ALPHA_W(ALPHA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .alpha_i   (alpha_i),
    .norm_sof_i(norm_sof_i),
    .norm_dat_i(norm_dat_i),
    .norm_par_i(norm_par_i),
    .norm_srb_i(norm_srb_i),
    .out_sof_o (out_sof_o),
    .out_dat_o (out_dat_o),
    .out_par_o (out_par_o),
    .out_srb_o (out_srb_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/fc_train_gen_tb.sv
module fc_train_gen_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] alpha_i = '0;
    logic          n_sof = 1'b0, n_par = 1'b0, n_srb = 1'b0;
    logic [3:0]    n_dat = '0;
    logic          o_sof, o_par, o_srb, busy, done;
    logic [3:0]    o_dat;
    logic [6:0]    lf = 7'h5A;

    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;

    fc_train_gen #(.ALPHA_W(AW), .HALF_LEN(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .alpha_i(alpha_i),
        .norm_sof_i(n_sof), .norm_dat_i(n_dat), .norm_par_i(n_par), .norm_srb_i(n_srb),
        .out_sof_o(o_sof), .out_dat_o(o_dat), .out_par_o(o_par), .out_srb_o(o_srb),
        .busy_o(busy), .done_o(done)
    );

    // act/exp packing: {busy, done, sof, dat[3:0], par, srb}
    task automatic chk(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = {busy, done, o_sof, o_dat, o_par, o_srb};
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t act=%b exp=%b", req, $time, act, exp);
        end
    endtask

    // Advance one cycle and put a fresh normal word on the inputs
    task automatic step();
        @(posedge clk);
        #2;
        lf = {lf[5:0], lf[6] ^ lf[5]};
        {n_sof, n_dat, n_par, n_srb} = lf;
    endtask

    function automatic logic [8:0] idle_exp();
        return {2'b00, n_sof, n_dat, n_par, n_srb};
    endfunction

    task automatic run(input int a, input bit hold_start, input bit scramble, input string tag);
        step();
        start_i = 1'b1;
        alpha_i = AW'(a);
        #2 chk({"R2 ", tag}, idle_exp());
        if (a == 0) begin
            step();
            start_i = 1'b0;
            #2 chk("R6 zero count", idle_exp());
            step();
            #2 chk("R6 zero count", idle_exp());
        end else begin
            for (int k = 0; k < 20 * a; k++) begin
                step();
                start_i = hold_start && (k < 20 * a - 1);
                if (scramble) alpha_i = {lf, 1'b1};
                #2;
                if ((k % 20) < 10)
                    chk({"R4 R3 R10 ", tag}, {1'b1, (k == 20 * a - 1), 7'b1110000});
                else
                    chk({"R5 R8 R10 ", tag}, {1'b1, (k == 20 * a - 1), 7'b0001111});
            end
            step();
            start_i = 1'b0;
            #2 chk({"R8 back to pass ", tag}, idle_exp());
        end
    endtask

    initial begin
        #3;
        chk("R1 reset", idle_exp());
        n_dat = 4'hA; n_srb = 1'b1;
        #2 chk("R1 reset pass", idle_exp());
        start_i = 1'b1; alpha_i = 8'd2;
        @(posedge clk); #2;
        chk("R1 reset holds", idle_exp());
        start_i = 1'b0;
        #5 rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            #2 chk("R2 passthrough", idle_exp());
        end
        for (int a = 0; a <= 6; a++) run(a, 1'b0, 1'b0, "sweep");
        run(3, 1'b1, 1'b0, "R9 start held");
        run(4, 1'b0, 1'b1, "R7 count scrambled");
        run(255, 1'b0, 1'b0, "R3 max count");
        run(1, 1'b0, 1'b0, "back to back");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule